// File: doc/BRIEF.md
# Host-to-Service Command Mailbox

This block is a small memory-mapped mailbox between a host processor and a service processor. The host sees a 256-byte register window on a simple 32-bit register bus. Four regions are mapped in it: a write-only command register, a read-only status register, a write-only 16-byte transmit buffer and a read-only 16-byte receive buffer. Writing the command register starts an exchange. The write sets busy, latches the command word and rings a one-cycle doorbell toward the service processor.

The service processor works through a plain handshake port. It reads the latched command word, which carries the payload size in bits [23:16]. It reads the transmit buffer one word at a time and writes response words into the receive buffer. It ends the exchange with a done strobe that carries an error flag and an 8-bit error code. If bit 8 of the command word was set, completion also produces a single-cycle pulse on the host interrupt. Because that interrupt is an edge, the host never has to clear it.

Top module: `ipc_mailbox`

## Requirements
- R1: After reset the status word reads zero except the initiator id field [15:8], which holds the INITIATOR_ID parameter (default 0x5A). host_irq and svc_doorbell are low.
- R2: A write to offset 0x00 while not busy latches the full word on svc_cmd and sets busy (status bit 0). svc_doorbell is high for exactly the one cycle that follows the write edge.
- R3: A write to offset 0x00 while busy is ignored: svc_cmd keeps its value and no doorbell follows. The write sets status bit 2 (overrun), which stays set until reset.
- R4: A svc_done strobe while busy clears busy and loads svc_err into status bit 1 and svc_err_code into status [23:16]. Status [7:4] always shows command bits [15:12] of the accepted command. A svc_done strobe while idle changes nothing.
- R5: When the accepted command had bit 8 set, host_irq is high for exactly the one cycle after the completing done edge. When bit 8 was clear, host_irq stays low.
- R6: Host writes at 0x80 + 4k (k = 0..3) update transmit word k, byte lane i when h_be[i] is set. Word k is visible on svc_tx_data when svc_tx_idx = k. Host reads of the transmit region return zero.
- R7: Service writes (svc_rx_we, svc_rx_idx, svc_rx_wdata) fill receive word k, which the host reads at 0x90 + 4k. With h_rd_byte set, the read returns byte lane h_addr[1:0] zero-extended. Host writes to the receive region are discarded.
- R8: h_rdata is registered: it is valid in the cycle after h_rd and zero in any cycle not following a read. Reads of the command register and of unmapped offsets return zero.
- R9: An accepted command clears the error bit and the error code of the previous exchange.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| h_wr | input | 1 | Host write strobe |
| h_rd | input | 1 | Host read strobe |
| h_rd_byte | input | 1 | Host read returns the single byte selected by h_addr[1:0] |
| h_addr | input | 8 | Host byte address within the window |
| h_wdata | input | 32 | Host write data |
| h_be | input | 4 | Host write byte enables (transmit buffer) |
| h_rdata | output | 32 | Host read data, one cycle after h_rd |
| host_irq | output | 1 | Completion pulse toward the host |
| svc_doorbell | output | 1 | One-cycle pulse toward the service processor |
| svc_cmd | output | 32 | Latched command word |
| svc_tx_idx | input | 2 | Transmit word select |
| svc_tx_data | output | 32 | Selected transmit word |
| svc_rx_we | input | 1 | Receive buffer write strobe |
| svc_rx_idx | input | 2 | Receive word select |
| svc_rx_wdata | input | 32 | Receive word data |
| svc_done | input | 1 | Completion strobe |
| svc_err | input | 1 | Error flag for the completion |
| svc_err_code | input | 8 | Error code for the completion |

## Verification
svc_doorbell and svc_cmd change one clock after the command write edge. Busy, the error fields and host_irq change one clock after the done edge. A read result on h_rdata appears one clock after the h_rd edge. svc_tx_data is combinational from the buffer, so a transmit write shows one edge later. The bench drives every input on the falling edge and samples at the next falling edge after the edge that captures it. It therefore reads each result exactly in its due cycle. It also checks the cycle after that, to confirm that the pulses have ended.

// File: rtl/ipc_mbx_pkg.sv
package ipc_mbx_pkg;
  localparam int DATA_W    = 32;
  localparam int ADDR_W    = 8;
  localparam int BUF_BYTES = 16;
  localparam int BUF_WORDS = BUF_BYTES / 4;

  localparam logic [ADDR_W-1:0] OFF_CMD  = 8'h00;
  localparam logic [ADDR_W-1:0] OFF_STAT = 8'h04;
  localparam logic [ADDR_W-1:0] OFF_TX   = 8'h80;
  localparam logic [ADDR_W-1:0] OFF_RX   = 8'h90;

  typedef enum logic [2:0] {RG_NONE, RG_CMD, RG_STAT, RG_TX, RG_RX} region_e;

  function automatic region_e region_of(input logic [ADDR_W-1:0] a);
    region_e r;
    r = RG_NONE;
    if (a[ADDR_W-1:2] == OFF_CMD[ADDR_W-1:2])       r = RG_CMD;
    else if (a[ADDR_W-1:2] == OFF_STAT[ADDR_W-1:2]) r = RG_STAT;
    else if (a >= OFF_TX && a < OFF_TX + BUF_BYTES) r = RG_TX;
    else if (a >= OFF_RX && a < OFF_RX + BUF_BYTES) r = RG_RX;
    return r;
  endfunction

  function automatic logic [DATA_W-1:0] pack_status(
      input logic busy, input logic err, input logic ovr,
      input logic [3:0] id, input logic [7:0] init, input logic [7:0] code);
    return {8'h00, code, init, id, 1'b0, ovr, err, busy};
  endfunction

  function automatic logic [DATA_W-1:0] lane_pick(
      input logic [DATA_W-1:0] w, input logic [1:0] lane);
    return {24'h0, w[8*lane +: 8]};
  endfunction
endpackage

// File: rtl/ipc_mbx_buf.sv
module ipc_mbx_buf #(
  parameter int WORDS = 4,
  parameter int W     = 32,
  localparam int IW   = $clog2(WORDS),
  localparam int NB   = W / 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [IW-1:0] widx,
  input  logic [W-1:0]  wdata,
  input  logic [NB-1:0] wbe,
  input  logic [IW-1:0] ridx,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [WORDS];

  for (genvar k = 0; k < WORDS; k++) begin : g_word
    for (genvar b = 0; b < NB; b++) begin : g_lane
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          mem[k][8*b +: 8] <= '0;
        else if (we && widx == IW'(k) && wbe[b])
          mem[k][8*b +: 8] <= wdata[8*b +: 8];
      end
    end
  end

  assign rdata = mem[ridx];
endmodule

// File: rtl/ipc_mbx_ctrl.sv
module ipc_mbx_ctrl #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cmd_wr,
  input  logic [W-1:0] cmd_wdata,
  input  logic         done,
  input  logic         err_in,
  input  logic [7:0]   code_in,
  output logic         accept,
  output logic         finish,
  output logic         busy,
  output logic         err,
  output logic         ovr,
  output logic [7:0]   code,
  output logic [W-1:0] cmd_q,
  output logic         doorbell,
  output logic         irq
);
  assign accept = cmd_wr && !busy;
  assign finish = done && busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      err      <= 1'b0;
      ovr      <= 1'b0;
      code     <= '0;
      cmd_q    <= '0;
      doorbell <= 1'b0;
      irq      <= 1'b0;
    end else begin
      doorbell <= accept;
      irq      <= finish && cmd_q[8];
      if (cmd_wr && busy) ovr <= 1'b1;
      if (accept) begin
        busy  <= 1'b1;
        cmd_q <= cmd_wdata;
        err   <= 1'b0;
        code  <= '0;
      end else if (finish) begin
        busy <= 1'b0;
        err  <= err_in;
        code <= code_in;
      end
    end
  end
endmodule

// File: rtl/ipc_mailbox.sv
module ipc_mailbox
  import ipc_mbx_pkg::*;
#(
  parameter logic [7:0] INITIATOR_ID = 8'h5A
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        h_wr,
  input  logic        h_rd,
  input  logic        h_rd_byte,
  input  logic [7:0]  h_addr,
  input  logic [31:0] h_wdata,
  input  logic [3:0]  h_be,
  output logic [31:0] h_rdata,
  output logic        host_irq,
  output logic        svc_doorbell,
  output logic [31:0] svc_cmd,
  input  logic [1:0]  svc_tx_idx,
  output logic [31:0] svc_tx_data,
  input  logic        svc_rx_we,
  input  logic [1:0]  svc_rx_idx,
  input  logic [31:0] svc_rx_wdata,
  input  logic        svc_done,
  input  logic        svc_err,
  input  logic [7:0]  svc_err_code
);
  localparam int IW = $clog2(BUF_WORDS);

  region_e     reg_sel;
  logic        cmd_wr, tx_wr;
  logic        cmd_accept, cmd_finish;
  logic        stat_busy, stat_err, stat_ovr;
  logic [7:0]  stat_code;
  logic [31:0] status_word, rx_word, rd_word;
  logic [IW-1:0] word_idx;

  assign reg_sel  = region_of(h_addr);
  assign word_idx = h_addr[2 +: IW];
  assign cmd_wr   = h_wr && reg_sel == RG_CMD;
  assign tx_wr    = h_wr && reg_sel == RG_TX;

  ipc_mbx_ctrl #(.W(DATA_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cmd_wr(cmd_wr), .cmd_wdata(h_wdata),
    .done(svc_done), .err_in(svc_err), .code_in(svc_err_code),
    .accept(cmd_accept), .finish(cmd_finish),
    .busy(stat_busy), .err(stat_err), .ovr(stat_ovr), .code(stat_code),
    .cmd_q(svc_cmd), .doorbell(svc_doorbell), .irq(host_irq)
  );

  ipc_mbx_buf #(.WORDS(BUF_WORDS), .W(DATA_W)) u_tx (
    .clk(clk), .rst_n(rst_n),
    .we(tx_wr), .widx(word_idx), .wdata(h_wdata), .wbe(h_be),
    .ridx(svc_tx_idx), .rdata(svc_tx_data)
  );

  ipc_mbx_buf #(.WORDS(BUF_WORDS), .W(DATA_W)) u_rx (
    .clk(clk), .rst_n(rst_n),
    .we(svc_rx_we), .widx(svc_rx_idx), .wdata(svc_rx_wdata), .wbe(4'hF),
    .ridx(word_idx), .rdata(rx_word)
  );

  assign status_word = pack_status(stat_busy, stat_err, stat_ovr,
                                   svc_cmd[15:12], INITIATOR_ID, stat_code);

  always_comb begin
    unique case (reg_sel)
      RG_STAT: rd_word = status_word;
      RG_RX:   rd_word = rx_word;
      default: rd_word = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      h_rdata <= '0;
    else if (h_rd)
      h_rdata <= h_rd_byte ? lane_pick(rd_word, h_addr[1:0]) : rd_word;
    else
      h_rdata <= '0;
  end
endmodule

// File: rtl/ipc_mbx_chk.sv
module ipc_mbx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_wr,
  input logic       busy,
  input logic       ovr,
  input logic       accept,
  input logic       finish,
  input logic       svc_done,
  input logic       svc_doorbell,
  input logic       host_irq,
  input logic       h_rd,
  input logic [31:0] h_rdata
);
  AST_DOORBELL_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && !busy) |=> (svc_doorbell && busy)); // R2
  AST_DOORBELL_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    svc_doorbell |=> !svc_doorbell); // R2
  AST_NO_DOORBELL_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && busy) |=> (!svc_doorbell && ovr)); // R3
  AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ovr |=> ovr); // R3
  AST_DONE_CLEARS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (svc_done && busy) |=> !busy); // R4
  AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    host_irq |=> !host_irq); // R5
  AST_IRQ_AFTER_FINISH: assert property (@(posedge clk) disable iff (!rst_n)
    host_irq |-> $past(finish)); // R5
  AST_RDATA_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !h_rd |=> (h_rdata == 32'h0)); // R8
  AST_ACCEPT_FINISH_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(accept && finish)); // R4
endmodule

bind ipc_mailbox ipc_mbx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .busy(stat_busy), .ovr(stat_ovr),
  .accept(cmd_accept), .finish(cmd_finish), .svc_done(svc_done),
  .svc_doorbell(svc_doorbell), .host_irq(host_irq), .h_rd(h_rd), .h_rdata(h_rdata)
);

// File: tb/tb_ipc_mailbox.sv
module tb_ipc_mailbox;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        h_wr = 0, h_rd = 0, h_rd_byte = 0;
  logic [7:0]  h_addr = 0;
  logic [31:0] h_wdata = 0;
  logic [3:0]  h_be = 0;
  logic [31:0] h_rdata, svc_cmd, svc_tx_data;
  logic        host_irq, svc_doorbell;
  logic [1:0]  svc_tx_idx = 0, svc_rx_idx = 0;
  logic        svc_rx_we = 0, svc_done = 0, svc_err = 0;
  logic [31:0] svc_rx_wdata = 0;
  logic [7:0]  svc_err_code = 0;

  int nchk = 0, nfail = 0;
  int unsigned seed = 32'd7;
  logic [31:0] tx_m [4];
  logic [31:0] rx_m [4];
  logic        m_busy, m_err, m_ovr;
  logic [7:0]  m_code;
  logic [31:0] m_cmd;

  always #2 clk = ~clk;

  ipc_mailbox dut (.*);

  function automatic logic [31:0] exp_stat(input logic b, input logic e, input logic o,
      input logic [31:0] c, input logic [7:0] k);
    return (32'(b)) | (32'(e) << 1) | (32'(o) << 2) | (32'(c[15:12]) << 4)
         | (32'h5A << 8) | (32'(k) << 16);
  endfunction

  function automatic logic [31:0] merge_be(input logic [31:0] old, input logic [31:0] nw,
      input logic [3:0] be);
    logic [31:0] r = old;
    for (int i = 0; i < 4; i++) if (be[i]) r[i*8 +: 8] = nw[i*8 +: 8];
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be);
    h_wr = 1; h_addr = a; h_wdata = d; h_be = be;
    @(posedge clk); @(negedge clk);
    h_wr = 0; h_be = 0;
  endtask

  task automatic bus_read(input logic [7:0] a, input bit bytewise, output logic [31:0] d);
    h_rd = 1; h_addr = a; h_rd_byte = bytewise;
    @(posedge clk); @(negedge clk);
    d = h_rdata;
    h_rd = 0; h_rd_byte = 0;
  endtask

  initial begin
    #(4 * 150000);
    nfail++;
    $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    logic [31:0] d, c2;
    logic [3:0]  be;
    logic [1:0]  k;
    void'($urandom(seed));
    for (int i = 0; i < 4; i++) begin tx_m[i] = 0; rx_m[i] = 0; end
    m_busy = 0; m_err = 0; m_ovr = 0; m_code = 0; m_cmd = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    bus_read(8'h04, 0, d);
    check(d == exp_stat(0,0,0,0,0), "R1 status", d, exp_stat(0,0,0,0,0));
    check(!host_irq && !svc_doorbell, "R1 pulses low", {host_irq, svc_doorbell}, 0);

    // R6 transmit buffer with random byte enables
    for (int n = 0; n < 24; n++) begin
      k = 2'($urandom); be = 4'($urandom); d = $urandom;
      bus_write(8'h80 + 8'(4*k), d, be);
      tx_m[k] = merge_be(tx_m[k], d, be);
    end
    bus_write(8'h84, 32'hA5A5_0001, 4'b0000);
    for (int i = 0; i < 4; i++) begin
      svc_tx_idx = 2'(i); #1;
      check(svc_tx_data == tx_m[i], "R6 tx word", svc_tx_data, tx_m[i]);
      bus_read(8'h80 + 8'(4*i), 0, d);
      check(d == 0, "R6 tx host read zero", d, 0);
    end

    // R8 write-only and unmapped reads, idle rdata
    bus_read(8'h00, 0, d);
    check(d == 0, "R8 cmd read zero", d, 0);
    bus_read(8'h40, 0, d);
    check(d == 0, "R8 unmapped read zero", d, 0);
    @(negedge clk);
    check(h_rdata == 0, "R8 rdata idle", h_rdata, 0);

    for (int it = 0; it < 10; it++) begin
      c2 = $urandom;
      if (it == 0) c2[8] = 1'b1;
      if (it == 1) c2[8] = 1'b0;
      bus_write(8'h00, c2, 4'h0);
      m_cmd = c2; m_busy = 1; m_err = 0; m_code = 0;
      check(svc_doorbell == 1, "R2 doorbell", svc_doorbell, 1);
      check(svc_cmd == m_cmd, "R2 latched cmd", svc_cmd, m_cmd);
      bus_read(8'h04, 0, d);
      check(svc_doorbell == 0, "R2 doorbell one cycle", svc_doorbell, 0);
      check(d == exp_stat(1,0,m_ovr,m_cmd,0), "R9 R2 status busy cleared err",
            d, exp_stat(1,0,m_ovr,m_cmd,0));

      // R3 overrun
      if (it % 3 == 1) begin
        bus_write(8'h00, ~c2, 4'h0);
        m_ovr = 1;
        check(svc_doorbell == 0, "R3 no doorbell", svc_doorbell, 0);
        check(svc_cmd == m_cmd, "R3 cmd kept", svc_cmd, m_cmd);
      end

      // R7 service fills receive buffer
      for (int i = 0; i < 4; i++) begin
        svc_rx_we = 1; svc_rx_idx = 2'(i); svc_rx_wdata = $urandom;
        rx_m[i] = svc_rx_wdata;
        @(posedge clk); @(negedge clk);
      end
      svc_rx_we = 0;

      // R4/R5 completion
      svc_done = 1; svc_err = 1'($urandom); svc_err_code = 8'($urandom);
      m_err = svc_err; m_code = svc_err_code; m_busy = 0;
      @(posedge clk); @(negedge clk);
      svc_done = 0;
      check(host_irq == m_cmd[8], "R5 irq on completion", host_irq, m_cmd[8]);
      bus_read(8'h04, 0, d);
      check(host_irq == 0, "R5 irq one cycle", host_irq, 0);
      check(d == exp_stat(0,m_err,m_ovr,m_cmd,m_code), "R4 status after done",
            d, exp_stat(0,m_err,m_ovr,m_cmd,m_code));

      // R4 done while idle is ignored
      svc_done = 1; svc_err = ~m_err; svc_err_code = ~m_code;
      @(posedge clk); @(negedge clk);
      svc_done = 0;
      check(host_irq == 0, "R4 idle done no irq", host_irq, 0);
      bus_read(8'h04, 0, d);
      check(d == exp_stat(0,m_err,m_ovr,m_cmd,m_code), "R4 idle done ignored",
            d, exp_stat(0,m_err,m_ovr,m_cmd,m_code));

      // R7 host write to receive region discarded, then word/byte reads
      k = 2'($urandom);
      bus_write(8'h90 + 8'(4*k), ~rx_m[k], 4'hF);
      for (int i = 0; i < 4; i++) begin
        bus_read(8'h90 + 8'(4*i), 0, d);
        check(d == rx_m[i], "R7 rx word", d, rx_m[i]);
      end
      for (int j = 0; j < 4; j++) begin
        bus_read(8'h90 + 8'(4*k) + 8'(j), 1, d);
        check(d == {24'h0, rx_m[k][8*j +: 8]}, "R7 rx byte", d, {24'h0, rx_m[k][8*j +: 8]});
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule